// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller of a multicycle processor datapath. The datapath has one memory for instructions and data, one ALU and a register that holds the ALU result. On each clock the controller looks at its current state, the 6-bit opcode held in the instruction register and the ALU zero flag. From these it drives every datapath control line: the PC, IR and register-file write strobes, the memory read and write strobes, the memory address select, the two ALU operand selects, the ALU operation, the immediate extension mode, the destination register select and the write-back source select.

Five instruction classes are sequenced: register-register arithmetic (R-type), OR with an immediate, load word, store word and branch-if-equal. Every instruction starts with a fetch state and then a decode state. In decode the controller fetches the operands and also computes a branch target. Because the target is ready that early, a branch needs only one more state. Each class then runs through its own short chain of fixed 4-bit state codes and returns to fetch. The state codes are: FETCH 0000, DECODE 0001, BR_EQ 0010, RT_EXEC 0100, RT_WB 0101, ORI_EXEC 0110, ORI_WB 0111, LD_ADDR 1000, LD_MEM 1001, LD_WB 1010, ST_ADDR 1011 and ST_MEM 1100. The transitions are:

- FETCH goes to DECODE.
- DECODE dispatches on the opcode.
- RT_EXEC goes to RT_WB, and ORI_EXEC goes to ORI_WB.
- LD_ADDR goes to LD_MEM, then to LD_WB.
- ST_ADDR goes to ST_MEM.
- BR_EQ, RT_WB, ORI_WB, LD_WB and ST_MEM go back to FETCH.

Top module: `mcc_ctrl`

## Requirements
- R1: A high `rst` sampled at a rising edge puts the controller into FETCH, from time zero or in the middle of an instruction, and it stays there while `rst` is held.
- R2: In FETCH the outputs are `mem_rd`=1, `addr_sel`=0 (PC), `ir_wr`=1, `src_a_sel`=0 (PC), `src_b_sel`=00 (constant 4), `alu_op`=00 (add), `pc_load`=1 and `pc_src`=0 (ALU result). The next state is always DECODE.
- R3: In DECODE the outputs are `src_a_sel`=0, `src_b_sel`=10 (extended immediate shifted left by 2), `alu_op`=00 and `ext_sign`=1, with no write strobe. The next state depends on the opcode: 000000 goes to RT_EXEC, 001101 to ORI_EXEC, 100011 to LD_ADDR, 101011 to ST_ADDR and 000100 to BR_EQ.
- R4: RT_EXEC drives `src_a_sel`=1 (rs), `src_b_sel`=01 (rt) and `alu_op`=10 (function code). RT_WB then drives `reg_wr`=1, `dst_sel`=1 (rd) and `wb_sel`=0 (ALU result register).
- R5: ORI_EXEC drives `src_a_sel`=1, `src_b_sel`=11 (extended immediate), `alu_op`=11 (OR) and `ext_sign`=0 (zero extension). ORI_WB then drives `reg_wr`=1, `dst_sel`=0 (rt) and `wb_sel`=0.
- R6: LD_ADDR drives `src_a_sel`=1, `src_b_sel`=11, `alu_op`=00 and `ext_sign`=1. LD_MEM drives `mem_rd`=1 and `addr_sel`=1 (ALU result register). LD_WB drives `reg_wr`=1, `dst_sel`=0 and `wb_sel`=1 (memory data).
- R7: ST_ADDR drives the same ALU controls as LD_ADDR. ST_MEM drives `mem_wr`=1 and `addr_sel`=1.
- R8: BR_EQ drives `src_a_sel`=1, `src_b_sel`=01, `alu_op`=01 (subtract) and `pc_src`=1. In this state `pc_load` follows `alu_zero`.
- R9: Any other opcode in DECODE leads back to FETCH, and no write strobe is raised in between.
- R10: Every output not named for a state takes its idle value: 0 for each strobe and select, `src_b_sel`=00, `alu_op`=00 and `ext_sign`=1. At most one of `ir_wr`, `reg_wr` and `mem_wr` is high in any cycle.
- R11: Outside BR_EQ, `alu_zero` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_load | output | 1 | PC write strobe |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU result register |
| ir_wr | output | 1 | Instruction register write strobe |
| reg_wr | output | 1 | Register file write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| src_a_sel | output | 1 | ALU operand A: 0 PC, 1 rs |
| src_b_sel | output | 2 | ALU operand B: 00 four, 01 rt, 10 ext<<2, 11 ext |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function code, 11 OR |
| ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |
| dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back source: 0 ALU result register, 1 memory data |

## Verification
The bench builds the block with its default 6-bit opcode width. That width makes all 64 opcode values reachable, so random draws hit both the five decoded opcodes and undecoded ones at DECODE. Driving `alu_zero` at random in every state covers the branch taken and not taken, and shows that the flag is ignored elsewhere. A reset asserted in the middle of an instruction checks recovery from a state other than FETCH.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH    = 4'b0000,
        ST_DECODE   = 4'b0001,
        ST_BR_EQ    = 4'b0010,
        ST_RT_EXEC  = 4'b0100,
        ST_RT_WB    = 4'b0101,
        ST_ORI_EXEC = 4'b0110,
        ST_ORI_WB   = 4'b0111,
        ST_LD_ADDR  = 4'b1000,
        ST_LD_MEM   = 4'b1001,
        ST_LD_WB    = 4'b1010,
        ST_ST_ADDR  = 4'b1011,
        ST_ST_MEM   = 4'b1100
    } ctl_state_e;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BREQ  = 6'b000100;

    localparam logic [1:0] ALU_ADD  = 2'b00;
    localparam logic [1:0] ALU_SUB  = 2'b01;
    localparam logic [1:0] ALU_FUNC = 2'b10;
    localparam logic [1:0] ALU_OR   = 2'b11;

    localparam logic [1:0] SRCB_FOUR = 2'b00;
    localparam logic [1:0] SRCB_RT   = 2'b01;
    localparam logic [1:0] SRCB_EXSH = 2'b10;
    localparam logic [1:0] SRCB_EXT  = 2'b11;

    typedef struct packed {
        logic       pc_wr_now;
        logic       pc_wr_if_zero;
        logic       pc_src;
        logic       ir_wr;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       src_a_sel;
        logic [1:0] src_b_sel;
        logic [1:0] alu_op;
        logic       ext_sign;
        logic       dst_sel;
        logic       wb_sel;
    } ctl_word_t;

endpackage

// File: rtl/mcc_dispatch.sv
module mcc_dispatch
    import mcc_pkg::*;
#(
    parameter int OPW = OPC_W
) (
    input  logic [OPW-1:0] opcode,
    output ctl_state_e     target
);
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: target = ST_RT_EXEC;
            OPC_ORI:   target = ST_ORI_EXEC;
            OPC_LOAD:  target = ST_LD_ADDR;
            OPC_STORE: target = ST_ST_ADDR;
            OPC_BREQ:  target = ST_BR_EQ;
            default:   target = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
    import mcc_pkg::*;
#(
    parameter int OPW = OPC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    output ctl_state_e     state_q
);
    ctl_state_e dispatch_tgt;
    ctl_state_e state_d;

    mcc_dispatch #(.OPW(OPW)) u_dispatch (
        .opcode (opcode),
        .target (dispatch_tgt)
    );

    always_comb begin
        unique case (state_q)
            ST_FETCH:    state_d = ST_DECODE;
            ST_DECODE:   state_d = dispatch_tgt;
            ST_RT_EXEC:  state_d = ST_RT_WB;
            ST_ORI_EXEC: state_d = ST_ORI_WB;
            ST_LD_ADDR:  state_d = ST_LD_MEM;
            ST_LD_MEM:   state_d = ST_LD_WB;
            ST_ST_ADDR:  state_d = ST_ST_MEM;
            ST_BR_EQ,
            ST_RT_WB,
            ST_ORI_WB,
            ST_LD_WB,
            ST_ST_MEM:   state_d = ST_FETCH;
            default:     state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/mcc_outs.sv
module mcc_outs
    import mcc_pkg::*;
(
    input  ctl_state_e state_q,
    output ctl_word_t  cw
);
    always_comb begin
        cw           = '0;
        cw.src_b_sel = SRCB_FOUR;
        cw.alu_op    = ALU_ADD;
        cw.ext_sign  = 1'b1;
        unique case (state_q)
            ST_FETCH: begin
                cw.mem_rd    = 1'b1;
                cw.ir_wr     = 1'b1;
                cw.pc_wr_now = 1'b1;
            end
            ST_DECODE: begin
                cw.src_b_sel = SRCB_EXSH;
            end
            ST_BR_EQ: begin
                cw.src_a_sel     = 1'b1;
                cw.src_b_sel     = SRCB_RT;
                cw.alu_op        = ALU_SUB;
                cw.pc_wr_if_zero = 1'b1;
                cw.pc_src        = 1'b1;
            end
            ST_RT_EXEC: begin
                cw.src_a_sel = 1'b1;
                cw.src_b_sel = SRCB_RT;
                cw.alu_op    = ALU_FUNC;
            end
            ST_RT_WB: begin
                cw.reg_wr  = 1'b1;
                cw.dst_sel = 1'b1;
            end
            ST_ORI_EXEC: begin
                cw.src_a_sel = 1'b1;
                cw.src_b_sel = SRCB_EXT;
                cw.alu_op    = ALU_OR;
                cw.ext_sign  = 1'b0;
            end
            ST_ORI_WB: begin
                cw.reg_wr = 1'b1;
            end
            ST_LD_ADDR, ST_ST_ADDR: begin
                cw.src_a_sel = 1'b1;
                cw.src_b_sel = SRCB_EXT;
            end
            ST_LD_MEM: begin
                cw.mem_rd   = 1'b1;
                cw.addr_sel = 1'b1;
            end
            ST_LD_WB: begin
                cw.reg_wr = 1'b1;
                cw.wb_sel = 1'b1;
            end
            ST_ST_MEM: begin
                cw.mem_wr   = 1'b1;
                cw.addr_sel = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
#(
    parameter int OPW = OPC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    input  logic           alu_zero,
    output logic           pc_load,
    output logic           pc_src,
    output logic           ir_wr,
    output logic           reg_wr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           addr_sel,
    output logic           src_a_sel,
    output logic [1:0]     src_b_sel,
    output logic [1:0]     alu_op,
    output logic           ext_sign,
    output logic           dst_sel,
    output logic           wb_sel
);
    ctl_state_e state_q;
    ctl_word_t  cw;

    mcc_seq #(.OPW(OPW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .state_q (state_q)
    );

    mcc_outs u_outs (
        .state_q (state_q),
        .cw      (cw)
    );

    assign pc_load   = cw.pc_wr_now | (cw.pc_wr_if_zero & alu_zero);
    assign pc_src    = cw.pc_src;
    assign ir_wr     = cw.ir_wr;
    assign reg_wr    = cw.reg_wr;
    assign mem_rd    = cw.mem_rd;
    assign mem_wr    = cw.mem_wr;
    assign addr_sel  = cw.addr_sel;
    assign src_a_sel = cw.src_a_sel;
    assign src_b_sel = cw.src_b_sel;
    assign alu_op    = cw.alu_op;
    assign ext_sign  = cw.ext_sign;
    assign dst_sel   = cw.dst_sel;
    assign wb_sel    = cw.wb_sel;
endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_zero,
    input logic       pc_load,
    input logic       pc_src,
    input logic       ir_wr,
    input logic       reg_wr,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       addr_sel,
    input logic       src_a_sel,
    input logic [1:0] src_b_sel,
    input logic [1:0] alu_op,
    input logic       ext_sign,
    input logic       dst_sel,
    input logic       wb_sel
);
    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) rst_seen_q <= rst;

    always @(negedge clk) begin
        if (rst_seen_q === 1'b1)
            assert_reset_fetch_R1: assert (ir_wr && mem_rd && !addr_sel);
    end

    assert_single_write_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({ir_wr, reg_wr, mem_wr}) <= 1);

    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (src_b_sel == 2'b10 && !src_a_sel && !ir_wr && !reg_wr && !mem_wr));

    assert_branch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b01 && src_a_sel && !alu_zero) |-> !pc_load);

    assert_rd_after_func_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && dst_sel) |-> $past(alu_op == 2'b10));

    assert_load_wb_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wb_sel) |-> $past(mem_rd && addr_sel));

    assert_store_addr_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(src_a_sel && src_b_sel == 2'b11 && alu_op == 2'b00));
endmodule

bind mcc_ctrl mcc_ctrl_chk u_chk (.*);

// File: tb/mcc_ctrl_bench.sv
module mcc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] opcode;
    logic       alu_zero;
    logic       pc_load, pc_src, ir_wr, reg_wr, mem_rd, mem_wr, addr_sel, src_a_sel;
    logic [1:0] src_b_sel, alu_op;
    logic       ext_sign, dst_sel, wb_sel;

    int checks = 0;
    int errors = 0;
    int exp_state = 0;
    bit after_reset = 1'b0;
    bit after_bad = 1'b0;

    always #10 clk = ~clk;

    mcc_ctrl u_mcc_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .pc_load(pc_load), .pc_src(pc_src), .ir_wr(ir_wr), .reg_wr(reg_wr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
        .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .alu_op(alu_op),
        .ext_sign(ext_sign), .dst_sel(dst_sel), .wb_sel(wb_sel)
    );

    // order: pc_load pc_src ir_wr reg_wr mem_rd mem_wr addr_sel src_a src_b alu_op ext dst wb
    function automatic logic [14:0] exp_vec(int s, logic z);
        logic ld, ps, ir, rw, mr, mw, ad, sa, ex, ds, wb;
        logic [1:0] sb, op;
        {ld, ps, ir, rw, mr, mw, ad, sa, ds, wb} = '0;
        sb = 2'b00; op = 2'b00; ex = 1'b1;
        case (s)
            0:  begin mr = 1; ir = 1; ld = 1; end
            1:  sb = 2'b10;
            2:  begin sa = 1; sb = 2'b01; op = 2'b01; ps = 1; ld = z; end
            4:  begin sa = 1; sb = 2'b01; op = 2'b10; end
            5:  begin rw = 1; ds = 1; end
            6:  begin sa = 1; sb = 2'b11; op = 2'b11; ex = 0; end
            7:  rw = 1;
            8, 11: begin sa = 1; sb = 2'b11; end
            9:  begin mr = 1; ad = 1; end
            10: begin rw = 1; wb = 1; end
            12: begin mw = 1; ad = 1; end
            default: ;
        endcase
        return {ld, ps, ir, rw, mr, mw, ad, sa, sb, op, ex, ds, wb};
    endfunction

    function automatic int dispatch(logic [5:0] op);
        case (op)
            6'b000000: return 4;
            6'b001101: return 6;
            6'b100011: return 8;
            6'b101011: return 11;
            6'b000100: return 2;
            default:   return 0;
        endcase
    endfunction

    function automatic int next_of(int s, logic [5:0] op);
        case (s)
            0: return 1;
            1: return dispatch(op);
            4: return 5;
            6: return 7;
            8: return 9;
            9: return 10;
            11: return 12;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int s, logic z);
        if (after_reset) return "R1";
        if (after_bad) return "R9";
        if (s == 2) return "R8";
        if (z) return "R11";
        case (s)
            0: return "R2";
            1: return "R3";
            4, 5: return "R4";
            6, 7: return "R5";
            8, 9, 10: return "R6";
            11, 12: return "R7";
            default: return "R10";
        endcase
    endfunction

    function automatic logic is_valid(logic [5:0] op);
        return (op == 6'b000000 || op == 6'b001101 || op == 6'b100011 ||
                op == 6'b101011 || op == 6'b000100);
    endfunction

    task automatic check_now();
        logic [14:0] act, exp;
        string t;
        act = {pc_load, pc_src, ir_wr, reg_wr, mem_rd, mem_wr, addr_sel, src_a_sel,
               src_b_sel, alu_op, ext_sign, dst_sel, wb_sel};
        exp = exp_vec(exp_state, alu_zero);
        t = tag_of(exp_state, alu_zero);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s state %0d: outputs %b expected %b", t, exp_state, act, exp);
        end
        checks++;
        if (($countones({ir_wr, reg_wr, mem_wr}) > 1)) begin
            errors++;
            $display("FAIL R10 state %0d: write strobes %b expected at most one",
                     exp_state, {ir_wr, reg_wr, mem_wr});
        end
    endtask

    // called at a negedge: apply inputs, check, advance one clock
    task automatic step(logic r, logic [5:0] op, logic z);
        rst = r; opcode = op; alu_zero = z;
        #1;
        check_now();
        @(posedge clk);
        if (r) begin
            exp_state = 0; after_reset = 1'b1; after_bad = 1'b0;
        end else begin
            after_bad = (exp_state == 1) && !is_valid(op);
            after_reset = 1'b0;
            exp_state = next_of(exp_state, op);
        end
        @(negedge clk);
    endtask

    task automatic run_op(logic [5:0] op, logic z);
        for (int k = 0; k < 6; k++) begin
            step(1'b0, op, z);
            if (exp_state == 0) break;
        end
    endtask

    initial begin
        rst = 1'b1; opcode = '0; alu_zero = 1'b0;
        void'($urandom(32'd20231));
        @(posedge clk); exp_state = 0; after_reset = 1'b1;
        @(negedge clk);
        step(1'b1, 6'b000000, 1'b0);       // R1 held reset
        // directed: each class, branch taken and not taken, bad opcode
        run_op(6'b000000, 1'b0);          // R4
        run_op(6'b001101, 1'b0);          // R5
        run_op(6'b100011, 1'b0);          // R6
        run_op(6'b101011, 1'b0);          // R7
        run_op(6'b000100, 1'b1);          // R8 taken
        run_op(6'b000100, 1'b0);          // R8 not taken
        run_op(6'b111111, 1'b0);          // R9
        run_op(6'b000000, 1'b1);          // R11
        // reset in mid-instruction
        step(1'b0, 6'b100011, 1'b0);
        step(1'b0, 6'b100011, 1'b0);
        step(1'b1, 6'b100011, 1'b0);      // R1 from LD_ADDR
        // random
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] op;
            case ($urandom % 7)
                0: op = 6'b000000;
                1: op = 6'b001101;
                2: op = 6'b100011;
                3: op = 6'b101011;
                4: op = 6'b000100;
                default: op = 6'($urandom);
            endcase
            step(($urandom % 400) == 0, op, 1'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule